// File: doc/BRIEF.md
# Speculative Load Tracking Table

This block tracks loads that were hoisted above earlier stores which might write the same memory. When such an early load issues, it writes an entry holding its destination register and the 8-byte memory granule it read. Every store that follows probes the table with its address, and every entry whose granule it touches is killed, because the value fetched early may now be stale. Later, a check operation names a register and asks whether the early value can still be used.

There are two kinds of check. A check-load that finds a live entry is satisfied and consumes the entry. If it finds no live entry, it asks for the load to be executed again. A recovery check that finds a live entry leaves the entry in place. If it finds none, it asks for a branch to recovery code. The table is fully associative. A register that already owns an entry reuses that entry. A new register takes the slot under a rotating pointer. A synchronous flush empties the table.

Top module: `spec_load_table`

## Requirements
- R1: After reset no entry is live, all check response outputs are low, and the first check of any register misses.
- R2: After an allocation of register r, a check of r presented in a later cycle raises `chk_done_o` and `chk_hit_o` in the cycle after the check is presented.
- R3: A check-load (`chk_kind_i` = 0) that hits clears the entry, so a second check-load of the same register misses.
- R4: A recovery check (`chk_kind_i` = 1) that hits leaves the entry live. A recovery check that misses raises `chk_recover_o`.
- R5: A store kills every live entry whose granule equals the store address with its low 3 bits dropped. A store to any other granule leaves the entry live.
- R6: When a store and a check of the same entry occur in the same cycle, the check sees the entry as already killed and misses.
- R7: A second allocation of a register that already owns a live entry overwrites that entry's address. After it, a store to the old granule no longer kills the entry, and a store to the new granule does.
- R8: Allocations of registers that own no live entry take slots in rotating order starting at slot 0. The allocation after ENTRIES of them evicts the first one and leaves the others live.
- R9: A flush makes every entry dead from the next cycle on.
- R10: In the cycle after a check, `chk_done_o` is high and exactly one of hit, reload and recover is high. A check-load miss raises `chk_reload_o`. When no check was presented, all four response outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Kill all entries |
| alloc_valid_i | input | 1 | Early load allocates an entry |
| alloc_reg_i | input | REG_W | Destination register of the early load |
| alloc_addr_i | input | ADDR_W | Byte address of the early load |
| store_valid_i | input | 1 | Store probe present |
| store_addr_i | input | ADDR_W | Byte address of the store |
| chk_valid_i | input | 1 | Check present |
| chk_kind_i | input | 1 | 0 = check-load, 1 = recovery check |
| chk_reg_i | input | REG_W | Register being checked |
| chk_done_o | output | 1 | A check was answered this cycle |
| chk_hit_o | output | 1 | The speculation held |
| chk_reload_o | output | 1 | A check-load missed, so the load must run again |
| chk_recover_o | output | 1 | A recovery check missed, so control goes to recovery code |

## Verification
The address comparison is swept over every load byte offset inside a granule against store offsets from one granule below to one granule above. This shows exact granule matching apart from any matching off by one granule in either direction. Sequences of checks of both kinds show a consuming hit apart from a non-consuming hit, and a reload apart from a recovery miss. A same-cycle store and check tests the ordering inside a cycle. Filling the table with one allocation beyond its size, and reallocating a register that already has an entry, show rotating replacement apart from in-place reuse.

// File: rtl/slt_pkg.sv
package slt_pkg;
    typedef enum logic {
        CHK_LOAD    = 1'b0,
        CHK_RECOVER = 1'b1
    } chk_kind_e;

    typedef struct packed {
        logic done;
        logic hit;
        logic reload;
        logic recover;
    } chk_resp_t;
endpackage

// File: rtl/slt_cam.sv
module slt_cam #(
    parameter int N     = 16,
    parameter int KEY_W = 8
) (
    input  logic [N-1:0]       valid_i,
    input  logic [N*KEY_W-1:0] keys_i,
    input  logic [KEY_W-1:0]   probe_i,
    output logic [N-1:0]       hit_o
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_o[g] = valid_i[g] && (keys_i[g*KEY_W +: KEY_W] == probe_i);
    end
endmodule

// File: rtl/slt_enc.sv
module slt_enc #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     onehot_i,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (onehot_i[i]) idx_o = idx_o | IDX_W'(i);
        end
    end
endmodule

// File: rtl/spec_load_table.sv
module spec_load_table #(
    parameter int ENTRIES = 16,
    parameter int REG_W   = 7,
    parameter int ADDR_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              alloc_valid_i,
    input  logic [REG_W-1:0]  alloc_reg_i,
    input  logic [ADDR_W-1:0] alloc_addr_i,
    input  logic              store_valid_i,
    input  logic [ADDR_W-1:0] store_addr_i,
    input  logic              chk_valid_i,
    input  logic              chk_kind_i,
    input  logic [REG_W-1:0]  chk_reg_i,
    output logic              chk_done_o,
    output logic              chk_hit_o,
    output logic              chk_reload_o,
    output logic              chk_recover_o
);
    import slt_pkg::*;

    localparam int GRAN_W = ADDR_W - 3;
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic [ENTRIES-1:0]        valid;
        logic [ENTRIES*REG_W-1:0]  regs;
        logic [ENTRIES*GRAN_W-1:0] grans;
        logic [IDX_W-1:0]          ptr;
        chk_resp_t                 resp;
    } state_t;

    state_t s_d, s_q;

    logic [ENTRIES-1:0] alloc_hit, chk_hit, st_hit;
    logic [ENTRIES-1:0] kill, chk_sel, clear, alloc_mask, kill_keep;
    logic [IDX_W-1:0]   alloc_idx, slot;
    logic [GRAN_W-1:0]  st_gran, al_gran;
    chk_kind_e          kind;

    assign st_gran = store_addr_i[ADDR_W-1:3];
    assign al_gran = alloc_addr_i[ADDR_W-1:3];
    assign kind    = chk_kind_e'(chk_kind_i);

    slt_cam #(.N(ENTRIES), .KEY_W(REG_W)) u_cam_alloc (
        .valid_i(s_q.valid), .keys_i(s_q.regs), .probe_i(alloc_reg_i), .hit_o(alloc_hit)
    );
    slt_cam #(.N(ENTRIES), .KEY_W(REG_W)) u_cam_chk (
        .valid_i(s_q.valid), .keys_i(s_q.regs), .probe_i(chk_reg_i), .hit_o(chk_hit)
    );
    slt_cam #(.N(ENTRIES), .KEY_W(GRAN_W)) u_cam_st (
        .valid_i(s_q.valid), .keys_i(s_q.grans), .probe_i(st_gran), .hit_o(st_hit)
    );
    slt_enc #(.N(ENTRIES), .IDX_W(IDX_W)) u_enc (
        .onehot_i(alloc_hit), .idx_o(alloc_idx)
    );

    always_comb begin
        s_d      = s_q;
        s_d.resp = '0;
        kill     = store_valid_i ? st_hit : '0;
        chk_sel  = chk_hit & ~kill;
        clear    = '0;
        if (chk_valid_i) begin
            s_d.resp.done = 1'b1;
            if (|chk_sel) begin
                s_d.resp.hit = 1'b1;
                if (kind == CHK_LOAD) clear = chk_sel;
            end else if (kind == CHK_LOAD) begin
                s_d.resp.reload = 1'b1;
            end else begin
                s_d.resp.recover = 1'b1;
            end
        end
        s_d.valid  = s_q.valid & ~kill & ~clear;
        slot       = (|alloc_hit) ? alloc_idx : s_q.ptr;
        alloc_mask = '0;
        if (alloc_valid_i) begin
            alloc_mask                          = ENTRIES'(1) << slot;
            s_d.valid                           = s_d.valid | alloc_mask;
            s_d.regs[slot*REG_W +: REG_W]       = alloc_reg_i;
            s_d.grans[slot*GRAN_W +: GRAN_W]    = al_gran;
            if (!(|alloc_hit)) begin
                s_d.ptr = (s_q.ptr == IDX_W'(ENTRIES-1)) ? '0 : s_q.ptr + 1'b1;
            end
        end
        if (flush_i) begin
            s_d.valid = '0;
            s_d.ptr   = '0;
        end
        kill_keep = kill & ~alloc_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign chk_done_o    = s_q.resp.done;
    assign chk_hit_o     = s_q.resp.hit;
    assign chk_reload_o  = s_q.resp.reload;
    assign chk_recover_o = s_q.resp.recover;

    // R7
    unique_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(alloc_hit));

    // R5
    store_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_valid_i |=> ((s_q.valid & $past(kill_keep)) == '0));

    // R9
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (s_q.valid == '0));

    // R10
    resp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_done_o |-> ($countones({chk_hit_o, chk_reload_o, chk_recover_o}) == 1));

    // R10
    resp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_done_o |-> !(chk_hit_o || chk_reload_o || chk_recover_o));

    // R2
    resp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid_i |=> chk_done_o);
endmodule

// File: tb/spec_load_table_bench.sv
`timescale 1ns/1ps
module spec_load_table_bench;
    localparam int ENTRIES = 16;
    localparam int REG_W   = 7;
    localparam int ADDR_W  = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush_i = 1'b0;
    logic alloc_valid_i = 1'b0;
    logic [REG_W-1:0] alloc_reg_i = '0;
    logic [ADDR_W-1:0] alloc_addr_i = '0;
    logic store_valid_i = 1'b0;
    logic [ADDR_W-1:0] store_addr_i = '0;
    logic chk_valid_i = 1'b0;
    logic chk_kind_i = 1'b0;
    logic [REG_W-1:0] chk_reg_i = '0;
    logic chk_done_o, chk_hit_o, chk_reload_o, chk_recover_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    spec_load_table #(.ENTRIES(ENTRIES), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_spec_load_table (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
        .alloc_valid_i(alloc_valid_i), .alloc_reg_i(alloc_reg_i), .alloc_addr_i(alloc_addr_i),
        .store_valid_i(store_valid_i), .store_addr_i(store_addr_i),
        .chk_valid_i(chk_valid_i), .chk_kind_i(chk_kind_i), .chk_reg_i(chk_reg_i),
        .chk_done_o(chk_done_o), .chk_hit_o(chk_hit_o),
        .chk_reload_o(chk_reload_o), .chk_recover_o(chk_recover_o)
    );

    task automatic expect_resp(input string req, input logic [3:0] exp);
        logic [3:0] act;
        act = {chk_done_o, chk_hit_o, chk_reload_o, chk_recover_o};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: done/hit/reload/recover actual %b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [3:0] outcome(input bit hit, input bit kind);
        if (hit) return 4'b1100;
        return kind ? 4'b1001 : 4'b1010;
    endfunction

    task automatic do_alloc(input int r, input logic [ADDR_W-1:0] a);
        alloc_valid_i = 1'b1; alloc_reg_i = REG_W'(r); alloc_addr_i = a;
        @(negedge clk);
        alloc_valid_i = 1'b0;
    endtask

    task automatic do_store(input logic [ADDR_W-1:0] a);
        store_valid_i = 1'b1; store_addr_i = a;
        @(negedge clk);
        store_valid_i = 1'b0;
    endtask

    task automatic do_flush();
        flush_i = 1'b1;
        @(negedge clk);
        flush_i = 1'b0;
    endtask

    task automatic do_check(input string req, input int r, input bit kind, input bit hit);
        chk_valid_i = 1'b1; chk_kind_i = kind; chk_reg_i = REG_W'(r);
        @(negedge clk);
        chk_valid_i = 1'b0;
        expect_resp(req, outcome(hit, kind));
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: outputs idle after reset, first check misses
        expect_resp("R1", 4'b0000);
        do_check("R1", 5, 1'b0, 1'b0);
        // R10: idle cycle after a check
        @(negedge clk);
        expect_resp("R10", 4'b0000);

        // R2, R3
        do_alloc(3, 32'h1000);
        do_check("R2", 3, 1'b0, 1'b1);
        do_check("R3", 3, 1'b0, 1'b0);

        // R4
        do_alloc(4, 32'h2000);
        do_check("R4", 4, 1'b1, 1'b1);
        do_check("R4", 4, 1'b1, 1'b1);
        do_store(32'h2004);
        do_check("R4", 4, 1'b1, 1'b0);

        // R5: sweep load offset in granule against store offsets -8..15
        for (int lo = 0; lo < 8; lo++) begin
            for (int so = -8; so < 16; so++) begin
                logic [ADDR_W-1:0] la, sa;
                bit same;
                la = 32'h0000_4000 + ADDR_W'(lo);
                sa = 32'h0000_4000 + ADDR_W'(so);
                same = ((la >> 3) == (sa >> 3));
                do_flush();
                do_alloc(9, la);
                do_store(sa);
                do_check("R5", 9, 1'b1, !same);
            end
        end

        // R6: store and check in the same cycle
        do_flush();
        do_alloc(6, 32'h3008);
        store_valid_i = 1'b1; store_addr_i = 32'h300F;
        chk_valid_i = 1'b1; chk_kind_i = 1'b0; chk_reg_i = 7'd6;
        @(negedge clk);
        store_valid_i = 1'b0; chk_valid_i = 1'b0;
        expect_resp("R6", 4'b1010);

        // R7: reallocation overwrites the address
        do_alloc(7, 32'h5000);
        do_alloc(7, 32'h6000);
        do_store(32'h5000);
        do_check("R7", 7, 1'b1, 1'b1);
        do_store(32'h6003);
        do_check("R7", 7, 1'b1, 1'b0);

        // R8: one allocation beyond capacity evicts the first
        do_flush();
        for (int k = 0; k <= ENTRIES; k++) do_alloc(k + 20, ADDR_W'(32'h8000 + k * 8));
        for (int k = 0; k <= ENTRIES; k++) do_check("R8", k + 20, 1'b1, k != 0);

        // R9: flush kills all
        do_alloc(1, 32'h9000);
        do_alloc(2, 32'h9100);
        do_flush();
        do_check("R9", 1, 1'b1, 1'b0);
        do_check("R9", 2, 1'b0, 1'b0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule